// File: doc/BRIEF.md
# Integer Execute Unit with Carry

This block executes one integer operation at a time on a private file of sixteen 64-bit registers. Every operation is destructive and has two operands. The destination register also supplies the first source. The second operand comes either from a register or from a zero-extended immediate, chosen by a select bit. Bitwise operations are available, along with add, subtract, increment, decrement, multiply and unsigned divide. The result is written back to the destination register. Add, subtract, increment and decrement also update a carry/borrow flag, which the surrounding core places in its processor state register.

Requests enter on a valid/ready handshake. A request is taken on any rising clock edge where `in_valid` and `in_ready` are both high. The caller must hold its fields steady while `in_valid` is high and `in_ready` is low. `in_ready` is high except while a divide is in progress. The result side has no back-pressure: `res_valid` is a one-cycle pulse, and the consumer must capture `res_data` and `res_wen` in that cycle. Register index 0 is a constant zero source. An operation that names it as destination still reports its result, but never writes it.

Top module: `int_exec_unit`

## Requirements
- R1: Register 0 always reads as zero. An operation whose destination is register 0 reports `res_wen` = 0 and leaves register 0 at zero, but `res_data` still shows the computed value.
- R2: Registers 1 to 15 hold the last value written to them. Reset clears every register, the carry flag and `res_valid`, and sets `in_ready` high.
- R3: AND (code 0), OR (code 1) and XOR (code 2) write destination op operand. The operand is register `in_src` when `in_use_imm` = 0. When `in_use_imm` = 1, it is the 16-bit `in_imm` zero-extended to 64 bits.
- R4: ADD (code 3) and SUB (code 4) produce the result modulo 2^64. ADD sets carry to the carry out of bit 63. SUB sets carry to 1 exactly when the operand is larger than the destination (a borrow).
- R5: INC (code 7) adds 1 and DEC (code 8) subtracts 1 from the destination, and ignore the operand. INC sets carry on wrap from all ones to zero. DEC sets carry on wrap from zero to all ones, and clears it otherwise.
- R6: MUL (code 5) writes the low 64 bits of the unsigned product.
- R7: DIV (code 6) writes the unsigned quotient. A zero divisor gives all ones.
- R8: Bitwise operations, MUL, DIV and unknown opcodes leave the carry flag unchanged.
- R9: An opcode above 8 is accepted, writes no register (`res_wen` = 0) and reports `res_data` = 0.
- R10: Every operation other than DIV raises `res_valid` for exactly the one cycle after the edge that accepts it. `in_ready` stays high throughout.
- R11: DIV drops `in_ready` from the edge that accepts it until its result. Its `res_valid` pulse comes DATA_W+1 cycles after the point where a one-cycle operation's pulse would come.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 4 | Operation code |
| in_dst | input | $clog2(REGS) | Destination and first-source register index |
| in_src | input | $clog2(REGS) | Second-source register index |
| in_imm | input | IMM_W | Immediate, zero-extended |
| in_use_imm | input | 1 | 1 selects the immediate as second operand |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Result value |
| res_wen | output | 1 | Result was written to the register file |
| carry_flag | output | 1 | Carry/borrow flag for the state register |

## Verification
The bench builds the unit with its default values: DATA_W = 64, sixteen registers and a 16-bit immediate. At full width, carry out of bit 63, borrow below zero and the all-ones wrap of INC and DEC can only be reached by chaining DEC and SUB from small immediates. The bench does this, so the sequence also tests that results persist in the register file. Because the divider is built at 64 bits, the bench measures the real stall of DATA_W+1 cycles, and it covers a zero divisor as well as a quotient whose top bits are zero.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_XOR = 4'd2,
    OP_ADD = 4'd3,
    OP_SUB = 4'd4,
    OP_MUL = 4'd5,
    OP_DIV = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8
  } iexu_op_e;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return op <= OP_DEC;
  endfunction

  function automatic logic op_sets_carry(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_DEC);
  endfunction

endpackage

// File: rtl/iexu_regfile.sv
module iexu_regfile #(
  parameter int DATA_W = 64,
  parameter int REGS   = 16,
  localparam int IDX_W = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra,
  input  logic [IDX_W-1:0]  rb,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);

  logic [DATA_W-1:0] mem [REGS];

  for (genvar i = 0; i < REGS; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign mem[i] = '0;
    end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          mem[i] <= '0;
        else if (we && waddr == IDX_W'(i))   mem[i] <= wdata;
      end
    end
  end

  assign rd_a = mem[ra];
  assign rd_b = mem[rb];

  // R1
  x0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra == '0) |-> (rd_a == '0));

endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
  import iexu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  logic [DATA_W:0] ext;

  always_comb begin
    res  = '0;
    cout = 1'b0;
    ext  = '0;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_ADD: begin
        ext  = {1'b0, a} + {1'b0, b};
        res  = ext[DATA_W-1:0];
        cout = ext[DATA_W];
      end
      OP_SUB: begin
        ext  = {1'b0, a} - {1'b0, b};
        res  = ext[DATA_W-1:0];
        cout = ext[DATA_W];
      end
      OP_INC: begin
        ext  = {1'b0, a} + (DATA_W+1)'(1);
        res  = ext[DATA_W-1:0];
        cout = ext[DATA_W];
      end
      OP_DEC: begin
        ext  = {1'b0, a} - (DATA_W+1)'(1);
        res  = ext[DATA_W-1:0];
        cout = ext[DATA_W];
      end
      OP_MUL: res = a * b;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/iexu_divider.sv
module iexu_divider #(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] quotient
);

  logic [DATA_W:0]   rem;
  logic [DATA_W-1:0] quo;
  logic [DATA_W-1:0] dvs;
  logic [CNT_W-1:0]  cnt;

  logic [DATA_W:0] shifted;
  logic [DATA_W:0] diff;
  logic            fits;

  always_comb begin
    shifted = {rem[DATA_W-1:0], quo[DATA_W-1]};
    diff    = shifted - {1'b0, dvs};
    fits    = shifted >= {1'b0, dvs};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      dvs  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        rem  <= '0;
        quo  <= dividend;
        dvs  <= divisor;
        cnt  <= CNT_W'(DATA_W);
        busy <= 1'b1;
      end else if (busy) begin
        rem <= fits ? diff : shifted;
        quo <= {quo[DATA_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo;

  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvs == '0) |-> (quotient == '1));

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REGS   = 16,
  parameter int IMM_W  = 16,
  localparam int IDX_W = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [IDX_W-1:0]  in_dst,
  input  logic [IDX_W-1:0]  in_src,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic              in_use_imm,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_wen,
  output logic              carry_flag
);

  logic              accept, is_div, div_start;
  logic              div_pend, div_busy, div_done;
  logic [IDX_W-1:0]  div_dst;
  logic [DATA_W-1:0] div_q;
  logic [DATA_W-1:0] opa, src_val, opb;
  logic [DATA_W-1:0] alu_res;
  logic              alu_cout;
  logic              rf_we;
  logic [IDX_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  assign in_ready  = !div_pend;
  assign accept    = in_valid && in_ready;
  assign is_div    = (in_op == OP_DIV);
  assign div_start = accept && is_div;
  assign opb       = in_use_imm ? DATA_W'(in_imm) : src_val;

  iexu_regfile #(.DATA_W(DATA_W), .REGS(REGS)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra    (in_dst),
    .rb    (in_src),
    .rd_a  (opa),
    .rd_b  (src_val)
  );

  iexu_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (in_op),
    .a    (opa),
    .b    (opb),
    .res  (alu_res),
    .cout (alu_cout)
  );

  iexu_divider #(.DATA_W(DATA_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (opa),
    .divisor  (opb),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_q)
  );

  always_comb begin
    if (div_done) begin
      rf_we    = (div_dst != '0);
      rf_waddr = div_dst;
      rf_wdata = div_q;
    end else begin
      rf_we    = accept && !is_div && op_known(in_op) && (in_dst != '0);
      rf_waddr = in_dst;
      rf_wdata = alu_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_pend   <= 1'b0;
      div_dst    <= '0;
      carry_flag <= 1'b0;
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_wen    <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      res_wen   <= 1'b0;
      if (div_start) begin
        div_pend <= 1'b1;
        div_dst  <= in_dst;
      end
      if (div_done) begin
        div_pend  <= 1'b0;
        res_valid <= 1'b1;
        res_data  <= div_q;
        res_wen   <= (div_dst != '0);
      end else if (accept && !is_div) begin
        res_valid <= 1'b1;
        res_data  <= alu_res;
        res_wen   <= op_known(in_op) && (in_dst != '0);
        if (op_sets_carry(in_op)) carry_flag <= alu_cout;
      end
    end
  end

  // R1
  x0_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_dst == '0) |=> !res_wen);

  // R4
  add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_ADD) |-> (alu_cout == (alu_res < opa)));

  // R8
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !op_sets_carry(in_op)) |=> $stable(carry_flag));

  // R10
  single_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_div) |=> res_valid);

  // R11
  div_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !in_ready);

endmodule

// File: tb/tb_int_exec_unit.sv
`timescale 1ns/1ps
module tb_int_exec_unit;

  localparam int DW = 64;
  localparam int NR = 16;
  localparam int IW = 16;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  dst;
    logic [3:0]  src;
    logic [15:0] imm;
    logic        sel;
    logic [63:0] exp;
    logic        wen;
    logic        cy;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 4'd1, 4'd0, 16'h00FF, 1'b1, 64'h00000000000000FF, 1'b1, 1'b0, 8'd3},  // R3 OR imm
    '{4'd3, 4'd1, 4'd0, 16'h0001, 1'b1, 64'h0000000000000100, 1'b1, 1'b0, 8'd4},  // R4 ADD
    '{4'd2, 4'd1, 4'd0, 16'h0F0F, 1'b1, 64'h0000000000000E0F, 1'b1, 1'b0, 8'd3},  // R3 XOR
    '{4'd0, 4'd1, 4'd0, 16'h00F0, 1'b1, 64'h0000000000000000, 1'b1, 1'b0, 8'd3},  // R3 AND
    '{4'd8, 4'd1, 4'd0, 16'h0000, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b1, 8'd5},  // R5 DEC wrap
    '{4'd1, 4'd2, 4'd0, 16'h0003, 1'b1, 64'h0000000000000003, 1'b1, 1'b1, 8'd8},  // R8 OR keeps carry
    '{4'd3, 4'd1, 4'd2, 16'h0000, 1'b0, 64'h0000000000000002, 1'b1, 1'b1, 8'd4},  // R4 ADD carry out
    '{4'd4, 4'd2, 4'd1, 16'h0000, 1'b0, 64'h0000000000000001, 1'b1, 1'b0, 8'd4},  // R4 SUB no borrow
    '{4'd4, 4'd2, 4'd0, 16'h0005, 1'b1, 64'hFFFFFFFFFFFFFFFC, 1'b1, 1'b1, 8'd4},  // R4 SUB borrow
    '{4'd7, 4'd1, 4'd0, 16'h0000, 1'b0, 64'h0000000000000003, 1'b1, 1'b0, 8'd5},  // R5 INC
    '{4'd5, 4'd2, 4'd1, 16'h0000, 1'b0, 64'hFFFFFFFFFFFFFFF4, 1'b1, 1'b0, 8'd6},  // R6 MUL wrap
    '{4'd6, 4'd2, 4'd0, 16'h0010, 1'b1, 64'h0FFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd7},  // R7 DIV
    '{4'd6, 4'd1, 4'd0, 16'h0000, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd7},  // R7 DIV by zero
    '{4'd7, 4'd1, 4'd0, 16'h0000, 1'b0, 64'h0000000000000000, 1'b1, 1'b1, 8'd5},  // R5 INC wrap
    '{4'd15,4'd2, 4'd0, 16'h1234, 1'b1, 64'h0000000000000000, 1'b0, 1'b1, 8'd9},  // R9 unknown op
    '{4'd1, 4'd2, 4'd0, 16'h0000, 1'b1, 64'h0FFFFFFFFFFFFFFF, 1'b1, 1'b1, 8'd9},  // R9 x2 untouched
    '{4'd3, 4'd0, 4'd0, 16'h0007, 1'b1, 64'h0000000000000007, 1'b0, 1'b0, 8'd1},  // R1 write to x0
    '{4'd1, 4'd3, 4'd0, 16'h0000, 1'b0, 64'h0000000000000000, 1'b1, 1'b0, 8'd1},  // R1 x0 reads zero
    '{4'd8, 4'd0, 4'd0, 16'h0000, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b1, 8'd1},  // R1 DEC x0
    '{4'd1, 4'd0, 4'd0, 16'h0000, 1'b1, 64'h0000000000000000, 1'b0, 1'b1, 8'd1},  // R1 x0 still zero
    '{4'd5, 4'd2, 4'd0, 16'h0010, 1'b1, 64'hFFFFFFFFFFFFFFF0, 1'b1, 1'b1, 8'd6},  // R6 MUL imm
    '{4'd6, 4'd2, 4'd2, 16'h0000, 1'b0, 64'h0000000000000001, 1'b1, 1'b1, 8'd7}   // R7 DIV self
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [3:0]    in_op = '0;
  logic [3:0]    in_dst = '0;
  logic [3:0]    in_src = '0;
  logic [IW-1:0] in_imm = '0;
  logic          in_use_imm = 1'b0;
  logic          res_valid;
  logic [DW-1:0] res_data;
  logic          res_wen;
  logic          carry_flag;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  int_exec_unit #(.DATA_W(DW), .REGS(NR), .IMM_W(IW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_op      (in_op),
    .in_dst     (in_dst),
    .in_src     (in_src),
    .in_imm     (in_imm),
    .in_use_imm (in_use_imm),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_wen    (res_wen),
    .carry_flag (carry_flag)
  );

  task automatic chk(input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input vec_t v, output int lat);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_op      = v.op;
    in_dst     = v.dst;
    in_src     = v.src;
    in_imm     = v.imm;
    in_use_imm = v.sel;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!res_valid && lat < 1000) begin
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    vec_t v;
    // R2 reset state
    repeat (3) @(negedge clk);
    chk(2, "in_ready in reset", 64'(in_ready), 64'd1);
    chk(2, "res_valid in reset", 64'(res_valid), 64'd0);
    chk(2, "carry in reset", 64'(carry_flag), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      run(v, lat);
      chk(v.req, $sformatf("vec %0d result", i), res_data, v.exp);
      chk(v.req, $sformatf("vec %0d wen", i), 64'(res_wen), 64'(v.wen));
      chk(v.req, $sformatf("vec %0d carry", i), 64'(carry_flag), 64'(v.cy));
      // R10 one-cycle latency, R11 divide latency
      chk((v.op == 4'd6) ? 11 : 10, $sformatf("vec %0d latency", i),
          64'(lat), (v.op == 4'd6) ? 64'(DW + 1) : 64'd0);
      @(negedge clk);
      chk(10, $sformatf("vec %0d pulse width", i), 64'(res_valid), 64'd0);
    end

    // R11 in_ready low during divide
    @(negedge clk);
    in_op = 4'd6; in_dst = 4'd3; in_src = 4'd0; in_imm = 16'h0003; in_use_imm = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(11, "in_ready during divide", 64'(in_ready), 64'd0);
    repeat (DW / 2) @(negedge clk);
    chk(11, "in_ready mid divide", 64'(in_ready), 64'd0);
    while (!res_valid) @(negedge clk);
    chk(11, "in_ready after divide", 64'(in_ready), 64'd1);

    // R10 in_ready stays high around a one-cycle op
    v = '{4'd1, 4'd2, 4'd0, 16'h0000, 1'b1, 64'h1, 1'b1, 1'b1, 8'd10};
    run(v, lat);
    chk(10, "in_ready with one-cycle op", 64'(in_ready), 64'd1);
    chk(2, "x2 retained", res_data, 64'h1);

    // R2 reset clears registers and carry
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(2, "carry after reset", 64'(carry_flag), 64'd0);
    v = '{4'd1, 4'd2, 4'd0, 16'h0000, 1'b1, 64'h0, 1'b1, 1'b0, 8'd2};
    run(v, lat);
    chk(2, "x2 cleared by reset", res_data, 64'h0);
    v = '{4'd1, 4'd1, 4'd0, 16'h0000, 1'b1, 64'h0, 1'b1, 1'b0, 8'd2};
    run(v, lat);
    chk(2, "x1 cleared by reset", res_data, 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule